// File: doc/BRIEF.md
# Half-Bridge Dead-Time Inserter

This block sits between a pulse-width generator and the gate drivers of one half-bridge leg. It takes a single high-side drive request and produces a high-side and a low-side gate signal that are complementary in steady state. Each time the request changes level, both gates are held off for a programmable number of system clock cycles, so the switch that is turning off has time to stop conducting before its partner turns on. The gap is counted in system clock cycles, so it does not depend on how fast the request toggles.

The gap length comes from a dead-time register that takes only its first write after reset. A software override can replace the generator's request. In that mode one control bit drives the high side through the same gap logic, and a second bit chooses whether the low side follows as that bit's complement or stays off.

The controller has three states. `ST_ARM` is entered at reset and holds both gates off for one cycle. The `arm` transition leaves it on the first clock: it captures the current request and moves to `ST_GAP`, or straight to `ST_PASS` when the dead-time is zero. `ST_GAP` counts down the gap with both gates off. Its `expire` transition goes to `ST_PASS` when the count runs out. Its `restart` transition reloads the full count when the request changes again. `ST_PASS` drives the gates from the captured request. Its `toggle` transition goes back to `ST_GAP` on a request change, or stays in `ST_PASS` and follows the new level at once when the dead-time is zero.

Top module: `dtg_pair`

## Requirements
- R1: With a dead-time value D greater than 0, a request change seen at a rising clock edge holds both gates low for exactly D clock cycles after that edge. The active gate drives high after the D-th following edge.
- R2: Only the first asserted write to the dead-time register after reset takes effect. Every later write is ignored until the next reset.
- R3: Every level change of the request (the generator input, or the override high-side bit when override is on) starts a new gap, and both gates are low during the gap.
- R4: The high-side and low-side gates are never high in the same cycle.
- R5: With override on, the generator input is ignored and the override high-side bit acts as the request. When the override low-side bit is 1, the low-side gate is the complement of the request outside a gap. When it is 0, the low-side gate is low. A change of the low-side bit alone takes effect after the next edge and starts no gap.
- R6: A request that stays high for W clock cycles, with W greater than D, gives a high-side pulse of W−D cycles.
- R7: A request change during a gap restarts the full count. A pulse shorter than D never turns on the high-side gate, and both gates stay low until D cycles after the last change.
- R8: With a dead-time of 0 (also the value before any write), the high-side gate follows the request one edge after it is sampled, and the low-side gate is its exact complement with no gap.
- R9: During reset and in the first cycle after reset, both gates are low. The dead-time register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_top_in | input | 1 | High-side drive request from the pulse-width generator |
| dt_wr_en | input | 1 | Write strobe for the dead-time register |
| dt_wr_data | input | DT_W | Dead-time value in clock cycles |
| ovr_en | input | 1 | Selects the software override as the request source |
| ovr_odd | input | 1 | Override high-side request |
| ovr_even | input | 1 | Override low-side enable (1: complement of high side, 0: off) |
| gate_top | output | 1 | High-side gate drive, active high |
| gate_bot | output | 1 | Low-side gate drive, active high |

## Verification
The assertions check on every cycle that the two gates never overlap. They also check that a request change followed by a nonzero dead-time blanks both gates on the next cycle, that the gap count stays within the locked value and reloads in full on a restart, that the register stays frozen once locked, and that the arm state lasts a single cycle. Only the bench scenarios can show the measured lengths: the exact gap, the shortened pulse width, a sub-gap pulse being swallowed, the second write being ignored, and the override bits steering the low side without a gap. A behavioural model compared on every clock covers these and a long pseudo-random stretch.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    typedef enum logic [1:0] {
        ST_ARM  = 2'd0,
        ST_GAP  = 2'd1,
        ST_PASS = 2'd2
    } dtg_state_e;
endpackage

// File: rtl/dtg_wo_reg.sv
module dtg_wo_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value
);
    logic         locked_q;
    logic [W-1:0] value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            value_q  <= '0;
        end else if (wr_en && !locked_q) begin
            locked_q <= 1'b1;
            value_q  <= wr_data;
        end
    end

    assign value = value_q;

    // R2: once locked, the stored value never moves again
    a_r2_frozen_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(value_q));
endmodule

// File: rtl/dtg_src_sel.sv
module dtg_src_sel (
    input  logic ovr_en,
    input  logic ovr_odd,
    input  logic pwm_in,
    output logic src
);
    always_comb begin
        src = ovr_en ? ovr_odd : pwm_in;
    end
endmodule

// File: rtl/dtg_pair.sv
module dtg_pair
    import dtg_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_top_in,
    input  logic            dt_wr_en,
    input  logic [DT_W-1:0] dt_wr_data,
    input  logic            ovr_en,
    input  logic            ovr_odd,
    input  logic            ovr_even,
    output logic            gate_top,
    output logic            gate_bot
);
    localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

    logic [DT_W-1:0] dt_val;
    logic            src;
    logic            lvl_q, lvl_d;
    logic            en_q, even_q;
    logic [DT_W-1:0] cnt_q, cnt_d;
    dtg_state_e      state_q, state_d;
    logic            req_edge;
    logic            load;

    dtg_wo_reg #(.W(DT_W)) u_dtreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dt_wr_en),
        .wr_data (dt_wr_data),
        .value   (dt_val)
    );

    dtg_src_sel u_sel (
        .ovr_en  (ovr_en),
        .ovr_odd (ovr_odd),
        .pwm_in  (pwm_top_in),
        .src     (src)
    );

    assign req_edge = (src != lvl_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lvl_d   = lvl_q;
        load    = 1'b0;
        unique case (state_q)
            ST_ARM:  load = 1'b1;
            ST_GAP: begin
                if (req_edge)             load    = 1'b1;
                else if (cnt_q <= CNT_ONE) state_d = ST_PASS;
                else                       cnt_d   = cnt_q - CNT_ONE;
            end
            ST_PASS: begin
                if (req_edge) load = 1'b1;
            end
            default: state_d = ST_ARM;
        endcase
        if (load) begin
            lvl_d = src;
            if (dt_val == '0) begin
                state_d = ST_PASS;
                cnt_d   = '0;
            end else begin
                state_d = ST_GAP;
                cnt_d   = dt_val;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARM;
            cnt_q   <= '0;
            lvl_q   <= 1'b0;
            en_q    <= 1'b0;
            even_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lvl_q   <= lvl_d;
            en_q    <= ovr_en;
            even_q  <= ovr_even;
        end
    end

    // outputs
    always_comb begin
        gate_top = 1'b0;
        gate_bot = 1'b0;
        unique case (state_q)
            ST_ARM, ST_GAP: begin
                gate_top = 1'b0;
                gate_bot = 1'b0;
            end
            ST_PASS: begin
                gate_top = lvl_q;
                gate_bot = en_q ? (even_q & ~lvl_q) : ~lvl_q;
            end
            default: begin
                gate_top = 1'b0;
                gate_bot = 1'b0;
            end
        endcase
    end

    // R4: the two gates never conduct together
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_top && gate_bot));

    // R3: a change with a nonzero dead-time blanks both gates next cycle
    a_r3_blank_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ARM && req_edge && dt_val != '0) |=> (!gate_top && !gate_bot));

    // R7: a change inside a gap reloads the full count
    a_r7_full_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && req_edge) |=> (cnt_q == $past(dt_val)));

    // R1: the gap count stays between 1 and the locked value
    a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (cnt_q != '0 && cnt_q <= dt_val));

    // R9: the arm state lasts exactly one cycle after reset
    a_r9_arm_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |=> (state_q != ST_ARM));
endmodule

// File: tb/sim_dtg_pair.sv
`timescale 1ns/1ps
module sim_dtg_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       en = 1'b0, odd = 1'b0, even = 1'b0;
    logic       g_top, g_bot;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_tag = "R4";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dtg_pair #(.DT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_top_in(pwm),
        .dt_wr_en(wr_en), .dt_wr_data(wr_data),
        .ovr_en(en), .ovr_odd(odd), .ovr_even(even),
        .gate_top(g_top), .gate_bot(g_bot)
    );

    // behavioural reference model
    bit m_init = 1, m_dead = 0, m_lvl = 0, m_en = 0, m_even = 0, m_locked = 0;
    int m_cnt = 0, m_dt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_init = 1; m_dead = 0; m_lvl = 0; m_en = 0; m_even = 0;
            m_locked = 0; m_cnt = 0; m_dt = 0;
        end else begin
            bit s;
            s = en ? odd : pwm;
            if (m_init || s != m_lvl) begin
                m_init = 0;
                m_lvl = s;
                if (m_dt == 0) m_dead = 0;
                else begin m_dead = 1; m_cnt = m_dt; end
            end else if (m_dead) begin
                if (m_cnt == 1) m_dead = 0;
                else m_cnt = m_cnt - 1;
            end
            m_en = en;
            m_even = even;
            if (wr_en && !m_locked) begin m_locked = 1; m_dt = wr_data; end
        end
    end

    task automatic check(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic check_int(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            bit et, eb;
            if (m_init || m_dead) begin et = 0; eb = 0; end
            else begin
                et = m_lvl;
                eb = m_en ? (m_even & ~m_lvl) : ~m_lvl;
            end
            check(cur_tag, "model top", g_top, et);
            check(cur_tag, "model bot", g_bot, eb);
            check("R4", "overlap", g_top & g_bot, 1'b0);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; pwm = 0; wr_en = 0; wr_data = 0; en = 0; odd = 0; even = 0;
        tick(3);
        check("R9", "top in reset", g_top, 1'b0);
        check("R9", "bot in reset", g_bot, 1'b0);
        rst_n = 1;
        check("R9", "top at release", g_top, 1'b0);
        check("R9", "bot at release", g_bot, 1'b0);
    endtask

    task automatic write_dt(logic [7:0] v);
        wr_en = 1; wr_data = v; tick(1); wr_en = 0;
    endtask

    initial begin
        int n;
        logic [15:0] lf;

        // R8 / R9: no write, dead-time 0
        cur_tag = "R8";
        do_reset();
        tick(3);
        check("R8", "idle bot", g_bot, 1'b1);
        pwm = 1; tick(1);
        check("R8", "top follows", g_top, 1'b1);
        check("R8", "bot complement", g_bot, 1'b0);
        pwm = 0; tick(1);
        check("R8", "top falls", g_top, 1'b0);
        check("R8", "bot rises", g_bot, 1'b1);

        // R1 / R2: first write 3, second write 9 ignored
        cur_tag = "R1";
        do_reset();
        write_dt(8'd3);
        write_dt(8'd9);
        tick(8);
        pwm = 1; n = 0;
        for (int i = 0; i < 40; i++) begin
            tick(1);
            if (!g_top && !g_bot) n++;
            else break;
        end
        check_int("R1", "gap length", n, 3);
        check_int("R2", "gap not from second write", n, 3);
        check("R1", "top after gap", g_top, 1'b1);
        cur_tag = "R3";
        pwm = 0; tick(1);
        check("R3", "blank top", g_top, 1'b0);
        check("R3", "blank bot", g_bot, 1'b0);
        tick(5);

        // R6: 6-cycle request gives 3-cycle pulse
        cur_tag = "R6";
        pwm = 1; n = 0;
        for (int i = 0; i < 6; i++) begin tick(1); if (g_top) n++; end
        pwm = 0;
        for (int i = 0; i < 6; i++) begin tick(1); if (g_top) n++; end
        check_int("R6", "shortened width", n, 3);

        // R7: 2-cycle pulse swallowed, gap restarts
        cur_tag = "R7";
        pwm = 1; n = 0;
        tick(1); if (!g_top && !g_bot) n++;
        tick(1); if (!g_top && !g_bot) n++;
        pwm = 0;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            check("R7", "no top pulse", g_top, 1'b0);
            if (!g_top && !g_bot) n++;
        end
        check_int("R7", "low span after restart", n, 5);

        // R5: override
        cur_tag = "R5";
        en = 1; odd = 0; even = 1; tick(2);
        check("R5", "bot by even", g_bot, 1'b1);
        odd = 1; tick(5);
        check("R5", "top by odd", g_top, 1'b1);
        check("R5", "bot off", g_bot, 1'b0);
        pwm = 1; tick(1); pwm = 0; tick(2);
        check("R5", "pwm ignored top", g_top, 1'b1);
        odd = 0; tick(5);
        check("R5", "bot after odd low", g_bot, 1'b1);
        even = 0; tick(1);
        check("R5", "even off bot", g_bot, 1'b0);
        check("R5", "even off top", g_top, 1'b0);
        even = 1; tick(1);
        check("R5", "even on no gap", g_bot, 1'b1);
        en = 0; tick(4);

        // R4 / R3: pseudo-random stretch with dead-time 2
        cur_tag = "R3";
        do_reset();
        write_dt(8'd2);
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            pwm = lf[0];
            en = (lf[7:5] == 3'd0);
            odd = lf[3];
            even = lf[9];
            tick(1);
        end
        en = 0; tick(4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule